// File: doc/BRIEF.md
# Expand Stage Kernel and Bias Feeder

This block sits beside a parallel convolution engine that computes the expand stage of a small convolutional network. Before a layer runs, a memory master writes the layer's weights into the block through a simple load port: 3x3 kernels, 1x1 kernels, and one bias per kernel for each of the two sets. The block keeps them in local RAM, split into four lanes so that four kernels can be read together. Once the final load word is flagged, the engine pulls kernels and biases from the block through two request/valid/ready channels.

Each kernel response carries a group of four 3x3 kernels and the four 1x1 kernels with the same indices. Kernel groups are handed out in the order the input feeder streams the input data. Within one depth slice the groups run from the first kernel to the last. The walk then moves to the next depth, and after the last depth it starts again at depth 0. Each bias response carries eight biases, four from each set, for one group of four kernels. The bias groups step forward and wrap independently of the kernel walk. A start pulse latches the layer shape (kernel groups per depth and number of depth slices). It also rewinds both walks and marks the weight store as not loaded until a new load completes.

Top module: `expand_kernel_feeder`

## Requirements
- R1: After reset both kValid and bValid are low.
- R2: A kernel or bias request raised before the load-complete marker (loadEn with loadLast) stays pending with its valid low, and it is served only after that marker.
- R3: In a kernel response for depth d and group g, lane j (bits [j*72 +: 72] of k3Out) holds 3x3 kernel 4g+j of depth d. Tap t (row-major, t = 3*row + col) is at bits [t*8 +: 8] of the lane.
- R4: In the same response, lane j of k1Out (bits [j*8 +: 8]) holds 1x1 kernel 4g+j of depth d.
- R5: Successive kernel responses step g from 0 to m/4-1 within a depth and then step d. After group m/4-1 of the last depth the next response is depth 0, group 0.
- R6: While kValid is high and kReady low, kValid stays high and k3Out and k1Out do not change. The same holds for bValid, b3Out and b1Out against bReady.
- R7: In a bias response for group g, lane j of b3Out and of b1Out (bits [j*8 +: 8]) holds the bias of kernel 4g+j of its set. Successive bias responses step g and wrap to 0 after group m/4-1.
- R8: A start pulse latches cfgGroups (m/4) and cfgDepth, clears both valids, and clears the load-complete state. The next kernel and bias responses after the new load are for depth 0, group 0.
- R9: loadSel selects the target: 0 a 3x3 kernel (all nine taps in loadData, tap t at bits [t*8 +: 8]), 1 a 1x1 kernel, 2 a 3x3-set bias, 3 a 1x1-set bias. The last three use loadData[7:0]. A kernel is addressed by loadIdx = d*m + k, and a bias by loadIdx = k.
- R10: A request accepted while the channel is idle or being emptied gives valid on the next clock edge. A handshake with no new request drops valid on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch layer shape, rewind walks, clear load-complete state |
| cfgGroups | input | GRPC_W (4) | Kernel groups of four per depth slice (m/4), 1..MAX_GROUPS |
| cfgDepth | input | DEPC_W (5) | Number of depth slices, 1..MAX_DEPTH |
| loadEn | input | 1 | Load word strobe from the memory master |
| loadSel | input | 2 | Load target: 0 3x3 kernel, 1 1x1 kernel, 2 3x3 bias, 3 1x1 bias |
| loadIdx | input | KIDX_W (9) | Kernel index d*m+k, or bias index k |
| loadData | input | 9*DATA_W (72) | Nine taps of a 3x3 kernel, or one value in the low byte |
| loadLast | input | 1 | Marks the final load word of the layer |
| kReq | input | 1 | Engine asks for the next kernel group |
| kReady | input | 1 | Engine takes the presented kernel group |
| kValid | output | 1 | Kernel group is presented |
| k3Out | output | LANES*9*DATA_W (288) | Four 3x3 kernels |
| k1Out | output | LANES*DATA_W (32) | Four 1x1 kernels |
| bReq | input | 1 | Engine asks for the next bias group |
| bReady | input | 1 | Engine takes the presented bias group |
| bValid | output | 1 | Bias group is presented |
| b3Out | output | LANES*DATA_W (32) | Four 3x3-set biases |
| b1Out | output | LANES*DATA_W (32) | Four 1x1-set biases |

## Verification
On every cycle the assertions check the handshake rules. Output data and valid must hold while the engine stalls, and a valid may only rise after the load-complete marker. A start must leave both channels idle and unloaded, and an accepted request must produce valid one edge later. The scenarios cover what needs a memory of earlier traffic: the exact tap placement in each lane, the depth-then-group walk and its wrap, the separate bias walk, and the rewind and reload after a mid-sequence start with a different layer shape.

// File: rtl/xfeed_pkg.sv
package xfeed_pkg;
  // taps of one 3x3 kernel, stored row-major
  localparam int TAPS = 9;

  typedef enum logic [1:0] {
    SEL_K3 = 2'd0,
    SEL_K1 = 2'd1,
    SEL_B3 = 2'd2,
    SEL_B1 = 2'd3
  } load_sel_e;

  // read strobes from control to datapath
  typedef struct packed {
    logic kRd;
    logic bRd;
  } feed_strobe_t;
endpackage

// File: rtl/xfeed_ctrl.sv
module xfeed_ctrl #(
  parameter int MAX_GROUPS = 8,
  parameter int MAX_DEPTH  = 16,
  localparam int ROWS   = MAX_GROUPS * MAX_DEPTH,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int GRP_W  = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
  localparam int GRPC_W = $clog2(MAX_GROUPS + 1),
  localparam int DEPC_W = $clog2(MAX_DEPTH + 1),
  localparam int TOT_W  = $clog2(ROWS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [GRPC_W-1:0]         cfgGroups,
  input  logic [DEPC_W-1:0]         cfgDepth,
  input  logic                      loadEn,
  input  logic                      loadLast,
  input  logic                      kReq,
  input  logic                      kReady,
  input  logic                      bReq,
  input  logic                      bReady,
  output xfeed_pkg::feed_strobe_t   strobe,
  output logic [ROW_W-1:0]          kRow,
  output logic [GRP_W-1:0]          bRow,
  output logic                      kValid,
  output logic                      bValid,
  output logic                      loaded
);
  logic [GRPC_W-1:0] grpQ;
  logic [TOT_W-1:0]  totQ;
  logic kIssue, bIssue, kWrap, bWrap;

  // a new read may start when the slot is empty or is being emptied now
  assign kIssue = loaded && !start && kReq && (!kValid || kReady);
  assign bIssue = loaded && !start && bReq && (!bValid || bReady);

  // rows are laid out depth-major, so the walk is a plain count to groups*depth
  assign kWrap = (TOT_W'(kRow) == totQ - TOT_W'(1));
  assign bWrap = (GRPC_W'(bRow) == grpQ - GRPC_W'(1));

  assign strobe.kRd = kIssue;
  assign strobe.bRd = bIssue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpQ   <= '0;
      totQ   <= '0;
      loaded <= 1'b0;
    end else if (start) begin
      grpQ   <= cfgGroups;
      totQ   <= TOT_W'(cfgGroups) * TOT_W'(cfgDepth);
      loaded <= 1'b0;
    end else if (loadEn && loadLast) begin
      loaded <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || start) begin
      kRow   <= '0;
      kValid <= 1'b0;
    end else begin
      if (kIssue) begin
        kRow   <= kWrap ? '0 : kRow + ROW_W'(1);
        kValid <= 1'b1;
      end else if (kReady) begin
        kValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || start) begin
      bRow   <= '0;
      bValid <= 1'b0;
    end else begin
      if (bIssue) begin
        bRow   <= bWrap ? '0 : bRow + GRP_W'(1);
        bValid <= 1'b1;
      end else if (bReady) begin
        bValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfeed_datapath.sv
module xfeed_datapath #(
  parameter int DATA_W     = 8,
  parameter int LANES      = 4,
  parameter int MAX_GROUPS = 8,
  parameter int MAX_DEPTH  = 16,
  localparam int TAPS   = xfeed_pkg::TAPS,
  localparam int KW     = TAPS * DATA_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROWS   = MAX_GROUPS * MAX_DEPTH,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int GRP_W  = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
  localparam int KIDX_W = ROW_W + LANE_W
) (
  input  logic                      clk,
  input  xfeed_pkg::feed_strobe_t   strobe,
  input  logic [ROW_W-1:0]          kRow,
  input  logic [GRP_W-1:0]          bRow,
  input  logic                      loadEn,
  input  logic [1:0]                loadSel,
  input  logic [KIDX_W-1:0]         loadIdx,
  input  logic [KW-1:0]             loadData,
  output logic [LANES*KW-1:0]       k3Out,
  output logic [LANES*DATA_W-1:0]   k1Out,
  output logic [LANES*DATA_W-1:0]   b3Out,
  output logic [LANES*DATA_W-1:0]   b1Out
);
  import xfeed_pkg::*;

  logic [LANE_W-1:0] wrLane;
  logic [ROW_W-1:0]  wrRow;
  logic [GRP_W-1:0]  wrBRow;
  load_sel_e         sel;

  // low index bits pick the lane, the rest the row inside that lane
  assign wrLane = loadIdx[LANE_W-1:0];
  assign wrRow  = loadIdx[KIDX_W-1:LANE_W];
  assign wrBRow = wrRow[GRP_W-1:0];
  assign sel    = load_sel_e'(loadSel);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [KW-1:0]     k3Mem [ROWS];
    logic [DATA_W-1:0] k1Mem [ROWS];
    logic [DATA_W-1:0] b3Mem [MAX_GROUPS];
    logic [DATA_W-1:0] b1Mem [MAX_GROUPS];
    logic [KW-1:0]     k3Q;
    logic [DATA_W-1:0] k1Q, b3Q, b1Q;
    logic              laneHit;

    assign laneHit = loadEn && (wrLane == LANE_W'(j));

    always_ff @(posedge clk) begin
      if (laneHit) begin
        case (sel)
          SEL_K3:  k3Mem[wrRow]  <= loadData;
          SEL_K1:  k1Mem[wrRow]  <= loadData[DATA_W-1:0];
          SEL_B3:  b3Mem[wrBRow] <= loadData[DATA_W-1:0];
          default: b1Mem[wrBRow] <= loadData[DATA_W-1:0];
        endcase
      end
    end

    // read registers hold their value until the next accepted request
    always_ff @(posedge clk) begin
      if (strobe.kRd) begin
        k3Q <= k3Mem[kRow];
        k1Q <= k1Mem[kRow];
      end
      if (strobe.bRd) begin
        b3Q <= b3Mem[bRow];
        b1Q <= b1Mem[bRow];
      end
    end

    assign k3Out[j*KW +: KW]         = k3Q;
    assign k1Out[j*DATA_W +: DATA_W] = k1Q;
    assign b3Out[j*DATA_W +: DATA_W] = b3Q;
    assign b1Out[j*DATA_W +: DATA_W] = b1Q;
  end
endmodule

// File: rtl/expand_kernel_feeder.sv
module expand_kernel_feeder #(
  parameter int DATA_W     = 8,
  parameter int LANES      = 4,
  parameter int MAX_GROUPS = 8,
  parameter int MAX_DEPTH  = 16,
  localparam int TAPS   = xfeed_pkg::TAPS,
  localparam int KW     = TAPS * DATA_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROWS   = MAX_GROUPS * MAX_DEPTH,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int GRP_W  = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
  localparam int GRPC_W = $clog2(MAX_GROUPS + 1),
  localparam int DEPC_W = $clog2(MAX_DEPTH + 1),
  localparam int KIDX_W = ROW_W + LANE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [GRPC_W-1:0]        cfgGroups,
  input  logic [DEPC_W-1:0]        cfgDepth,
  input  logic                     loadEn,
  input  logic [1:0]               loadSel,
  input  logic [KIDX_W-1:0]        loadIdx,
  input  logic [KW-1:0]            loadData,
  input  logic                     loadLast,
  input  logic                     kReq,
  input  logic                     kReady,
  output logic                     kValid,
  output logic [LANES*KW-1:0]      k3Out,
  output logic [LANES*DATA_W-1:0]  k1Out,
  input  logic                     bReq,
  input  logic                     bReady,
  output logic                     bValid,
  output logic [LANES*DATA_W-1:0]  b3Out,
  output logic [LANES*DATA_W-1:0]  b1Out
);
  xfeed_pkg::feed_strobe_t strobe;
  logic [ROW_W-1:0] kRow;
  logic [GRP_W-1:0] bRow;
  logic             loadedFlag;

  xfeed_ctrl #(
    .MAX_GROUPS(MAX_GROUPS),
    .MAX_DEPTH (MAX_DEPTH)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgGroups(cfgGroups),
    .cfgDepth (cfgDepth),
    .loadEn   (loadEn),
    .loadLast (loadLast),
    .kReq     (kReq),
    .kReady   (kReady),
    .bReq     (bReq),
    .bReady   (bReady),
    .strobe   (strobe),
    .kRow     (kRow),
    .bRow     (bRow),
    .kValid   (kValid),
    .bValid   (bValid),
    .loaded   (loadedFlag)
  );

  xfeed_datapath #(
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .MAX_GROUPS(MAX_GROUPS),
    .MAX_DEPTH (MAX_DEPTH)
  ) dp_i (
    .clk     (clk),
    .strobe  (strobe),
    .kRow    (kRow),
    .bRow    (bRow),
    .loadEn  (loadEn),
    .loadSel (loadSel),
    .loadIdx (loadIdx),
    .loadData(loadData),
    .k3Out   (k3Out),
    .k1Out   (k1Out),
    .b3Out   (b3Out),
    .b1Out   (b1Out)
  );
endmodule

// File: rtl/xfeed_checker.sv
module xfeed_checker #(
  parameter int K3W = 288,
  parameter int NW  = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           kReady,
  input logic           kValid,
  input logic [K3W-1:0] k3Out,
  input logic [NW-1:0]  k1Out,
  input logic           bReady,
  input logic           bValid,
  input logic [NW-1:0]  b3Out,
  input logic [NW-1:0]  b1Out,
  input logic           loadedFlag,
  input logic           kIssue,
  input logic           bIssue
);
  // R2
  kvalid_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kValid) |-> $past(loadedFlag));

  // R2
  bvalid_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bValid) |-> $past(loadedFlag));

  // R6
  kernel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kValid && !kReady && !start) |=> (kValid && $stable(k3Out) && $stable(k1Out)));

  // R6
  bias_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady && !start) |=> (bValid && $stable(b3Out) && $stable(b1Out)));

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!kValid && !bValid && !loadedFlag));

  // R10
  kernel_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    kIssue |=> kValid);

  // R10
  bias_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    bIssue |=> bValid);

  // R10
  kernel_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kValid && kReady && !kIssue) |=> !kValid);
endmodule

bind expand_kernel_feeder xfeed_checker #(
  .K3W(LANES * TAPS * DATA_W),
  .NW (LANES * DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .kReady    (kReady),
  .kValid    (kValid),
  .k3Out     (k3Out),
  .k1Out     (k1Out),
  .bReady    (bReady),
  .bValid    (bValid),
  .b3Out     (b3Out),
  .b1Out     (b1Out),
  .loadedFlag(loadedFlag),
  .kIssue    (strobe.kRd),
  .bIssue    (strobe.bRd)
);

// File: tb/expand_kernel_feeder_tb_top.sv
`timescale 1ns/1ps
module expand_kernel_feeder_tb_top;
  localparam int DW = 8;
  localparam int LN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfgGroups = '0;
  logic [4:0]  cfgDepth = '0;
  logic        loadEn = 1'b0;
  logic [1:0]  loadSel = '0;
  logic [8:0]  loadIdx = '0;
  logic [71:0] loadData = '0;
  logic        loadLast = 1'b0;
  logic        kReq = 1'b0, kReady = 1'b0, bReq = 1'b0, bReady = 1'b0;
  logic        kValid, bValid;
  logic [287:0] k3Out;
  logic [31:0]  k1Out, b3Out, b1Out;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  expand_kernel_feeder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgGroups(cfgGroups), .cfgDepth(cfgDepth),
    .loadEn(loadEn), .loadSel(loadSel), .loadIdx(loadIdx), .loadData(loadData),
    .loadLast(loadLast), .kReq(kReq), .kReady(kReady), .kValid(kValid),
    .k3Out(k3Out), .k1Out(k1Out), .bReq(bReq), .bReady(bReady), .bValid(bValid),
    .b3Out(b3Out), .b1Out(b1Out)
  );

  // weight patterns, distinct per tap, kernel, depth and load round
  function automatic logic [7:0] k3Byte(int s, int d, int k, int t);
    return 8'((s * 71 + d * 37 + k * 11 + t * 3 + 1) & 255);
  endfunction
  function automatic logic [7:0] k1Byte(int s, int d, int k);
    return 8'((s * 19 + d * 53 + k * 7 + 5) & 255);
  endfunction
  function automatic logic [7:0] b3Byte(int s, int k);
    return 8'((s * 23 + k * 13 + 2) & 255);
  endfunction
  function automatic logic [7:0] b1Byte(int s, int k);
    return 8'((s * 41 + k * 29 + 9) & 255);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic doStart(input int g, input int d);
    @(negedge clk);
    start = 1'b1; cfgGroups = 4'(g); cfgDepth = 5'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic loadWord(input logic [1:0] sel, input int idx, input logic [71:0] data,
                          input bit last);
    loadEn = 1'b1; loadSel = sel; loadIdx = 9'(idx); loadData = data; loadLast = last;
    @(negedge clk);
    loadEn = 1'b0; loadLast = 1'b0;
  endtask

  // R9: loadSel 0/1/2/3 targets, kernel index d*m+k, bias index k
  task automatic loadAll(input int s, input int g, input int d);
    int m;
    logic [71:0] w;
    m = 4 * g;
    for (int dd = 0; dd < d; dd++) begin
      for (int k = 0; k < m; k++) begin
        for (int t = 0; t < 9; t++) w[t*8 +: 8] = k3Byte(s, dd, k, t);
        loadWord(2'd0, dd * m + k, w, 1'b0);
        loadWord(2'd1, dd * m + k, {64'h0, k1Byte(s, dd, k)}, 1'b0);
      end
    end
    for (int k = 0; k < m; k++) begin
      loadWord(2'd2, k, {64'h0, b3Byte(s, k)}, 1'b0);
      loadWord(2'd3, k, {64'h0, b1Byte(s, k)}, k == m - 1);
    end
  endtask

  // request one kernel group and compare it; hold stalls the consumer
  task automatic fetchK(input string req, input int s, input int d, input int g,
                        input int m, input int hold);
    logic [287:0] e3;
    logic [31:0]  e1;
    logic [287:0] snap3;
    int n;
    for (int j = 0; j < LN; j++) begin
      for (int t = 0; t < 9; t++) e3[j*72 + t*8 +: 8] = k3Byte(s, d, 4 * g + j, t);
      e1[j*8 +: 8] = k1Byte(s, d, 4 * g + j);
    end
    kReq = 1'b1;
    @(negedge clk);
    n = 0;
    while (!kValid && n < 40) begin @(negedge clk); n++; end
    check(req, "kValid", 288'(kValid), 288'(1));
    // R3 taps row-major per lane, R4 1x1 lanes
    check({req, " R3"}, $sformatf("k3Out d%0d g%0d", d, g), k3Out, e3);
    check({req, " R4"}, $sformatf("k1Out d%0d g%0d", d, g), 288'(k1Out), 288'(e1));
    kReq = 1'b0;
    snap3 = k3Out;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6", "kValid held", 288'(kValid), 288'(1));
      check("R6", "k3Out stable", k3Out, snap3);
    end
    kReady = 1'b1;
    @(negedge clk);
    kReady = 1'b0;
  endtask

  task automatic fetchB(input string req, input int s, input int g, input int hold);
    logic [31:0] e3, e1, snap;
    int n;
    for (int j = 0; j < LN; j++) begin
      e3[j*8 +: 8] = b3Byte(s, 4 * g + j);
      e1[j*8 +: 8] = b1Byte(s, 4 * g + j);
    end
    bReq = 1'b1;
    @(negedge clk);
    n = 0;
    while (!bValid && n < 40) begin @(negedge clk); n++; end
    check(req, "bValid", 288'(bValid), 288'(1));
    check(req, $sformatf("b3Out g%0d", g), 288'(b3Out), 288'(e3));
    check(req, $sformatf("b1Out g%0d", g), 288'(b1Out), 288'(e1));
    bReq = 1'b0;
    snap = b3Out;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6", "bias held", 288'({bValid, b3Out}), 288'({1'b1, snap}));
    end
    bReady = 1'b1;
    @(negedge clk);
    bReady = 1'b0;
  endtask

  task automatic testReset();
    // R1
    check("R1", "kValid after reset", 288'(kValid), 288'(0));
    check("R1", "bValid after reset", 288'(bValid), 288'(0));
  endtask

  task automatic testStallThenFirst();
    doStart(2, 3);
    kReq = 1'b1; bReq = 1'b1;
    repeat (5) @(negedge clk);
    // R2: no response before the load-complete marker
    check("R2", "kValid before load", 288'(kValid), 288'(0));
    check("R2", "bValid before load", 288'(bValid), 288'(0));
    loadAll(0, 2, 3);
    bReq = 1'b0;
    fetchK("R2 R9", 0, 0, 0, 8, 0);
    fetchB("R2 R7", 0, 0, 0);
  endtask

  task automatic testOrder();
    // R5: groups inside a depth, then depths, then wrap
    fetchK("R5", 0, 0, 1, 8, 0);
    fetchK("R5", 0, 1, 0, 8, 0);
    fetchK("R5", 0, 1, 1, 8, 0);
    fetchK("R5", 0, 2, 0, 8, 0);
    fetchK("R5", 0, 2, 1, 8, 0);
    fetchK("R5 wrap", 0, 0, 0, 8, 0);
  endtask

  task automatic testHold();
    fetchK("R6", 0, 0, 1, 8, 4);
  endtask

  task automatic testBias();
    // R7: bias walk independent of kernel walk, wraps after m/4 groups
    fetchB("R7", 0, 1, 3);
    fetchB("R7 wrap", 0, 0, 0);
  endtask

  task automatic testLatency();
    // R10: valid one edge after an accepted request, drops after handshake
    kReq = 1'b1;
    @(negedge clk);
    check("R10", "kValid one cycle later", 288'(kValid), 288'(1));
    kReq = 1'b0; kReady = 1'b1;
    @(negedge clk);
    kReady = 1'b0;
    check("R10", "kValid dropped", 288'(kValid), 288'(0));
  endtask

  task automatic testRestart();
    // R8: mid-sequence start rewinds, clears load state, new shape m=4 depth=2
    kReq = 1'b1;
    @(negedge clk);
    start = 1'b1; cfgGroups = 4'd1; cfgDepth = 5'd2;
    @(negedge clk);
    start = 1'b0;
    check("R8", "kValid after start", 288'(kValid), 288'(0));
    repeat (3) @(negedge clk);
    check("R8", "stalled until reload", 288'(kValid), 288'(0));
    kReq = 1'b0;
    kReady = 1'b1; @(negedge clk); kReady = 1'b0;
    loadAll(5, 1, 2);
    fetchK("R8", 5, 0, 0, 4, 0);
    fetchK("R8 R5", 5, 1, 0, 4, 0);
    fetchK("R8 R5 wrap", 5, 0, 0, 4, 0);
    fetchB("R8 R7", 5, 0, 0);
    fetchB("R8 R7 wrap", 5, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStallThenFirst();
    testOrder();
    testHold();
    testBias();
    testLatency();
    testRestart();
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule